// File: doc/BRIEF.md
# Bus Trace Buffer Recorder

This block records processor activity into a 64-line on-chip trace memory for later dumping. Each line is 20 bits: a 4-bit upper field followed by two 8-bit fields. In the two program-flow modes one line holds one 18-bit program-counter value. In the data-access mode each qualifying access takes two consecutive lines. The first line carries the access size, the direction and the 18-bit address. The second line carries the data bytes.

A one-cycle arm pulse clears the buffer and starts recording. Store strobes then fill the memory from line 0 upward until all lines are used. A registered line counter and full flag report progress. Any line can be read back at any time through an index input and a combinational read port.

Top module: `trace_recorder`

## Requirements
- R1: After reset the line count is 0, the full flag is low and the recorder is disarmed: store strobes change neither the count nor the memory until the first arm pulse.
- R2: An arm pulse sets the count to 0, clears the full flag, forgets the last stored program counter, drops any pending data line and enables recording from the next cycle.
- R3: In normal mode (mode code 0) every strobe writes the line {2'b00, pc[17:16], pc[15:8], pc[7:0]} at the index equal to the count, and the count rises by one in the following cycle.
- R4: In loop mode (mode code 1) the line format matches R3, but a strobe whose pc equals the most recently stored pc is not recorded. A different pc, including one seen earlier, is recorded.
- R5: In detail mode (mode code 2) a strobe writes an address line at index n: bit 19 is 1 for a byte access and 0 for a word access, bit 18 is 1 for a read, bits 17:16 are addr[17:16], and bits 15:0 are addr[15:0]. In the next cycle the data line is written at index n+1 with bits 19:16 zero. The count rises by one in each of the two cycles.
- R6: For a word access, the byte at the lower address (data_i[7:0]) goes to line bits 15:8 and the byte at the higher address (data_i[15:8]) goes to bits 7:0.
- R7: For a byte access, data_i[7:0] goes to line bits 7:0 and bits 15:8 are zero.
- R8: A strobe in the cycle in which a detail data line is being written is ignored.
- R9: When the count reaches 64 the full flag rises, the count holds at 64, and further strobes leave the memory unchanged until the next arm. The count never exceeds 64, so at most 32 detail entries fit.
- R10: rd_line_o shows the line selected by rd_idx_i in the same cycle, without a clock edge.
- R11: Mode code 3 is reserved. Strobes in that mode are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 0 normal, 1 loop, 2 detail, 3 reserved |
| arm_i | input | 1 | One-cycle pulse: clear and start recording |
| store_i | input | 1 | Store strobe |
| pc_i | input | 18 | Program counter for normal and loop modes |
| addr_i | input | 18 | Access address for detail mode |
| data_i | input | 16 | Access data; [7:0] lower-address byte |
| size_byte_i | input | 1 | 1 = byte access, 0 = word access |
| read_i | input | 1 | 1 = read access, 0 = write access |
| rd_idx_i | input | 6 | Line index for dumping |
| rd_line_o | output | 20 | Addressed trace line |
| line_cnt_o | output | 7 | Lines written since arm |
| full_o | output | 1 | All lines used |

## Verification
The assertions check on every cycle that the count stays within 64 and agrees with the full flag. They also check that the count moves by at most one line per cycle, that an arm empties the buffer, that a full buffer stays frozen, that a pending data line always advances the count, and that the reserved mode never records. Only the bench scenarios can show the stored contents. That covers the bit packing of program-counter, address and data lines, the byte placement for word and byte accesses, the loop-mode duplicate filter against an arithmetic model, and that strobes rejected while disarmed, while full or during a data-line cycle leave the memory untouched.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_LOOP   = 2'd1,
    MODE_DETAIL = 2'd2,
    MODE_RSVD   = 2'd3
  } trc_mode_e;
endpackage

// File: rtl/trc_line_fmt.sv
module trc_line_fmt #(
  parameter int AW = 18,
  parameter int DW = 16,
  parameter int LW = 20
) (
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          size_byte,
  input  logic          is_read,
  output logic [LW-1:0] pc_line,
  output logic [LW-1:0] addr_line,
  output logic [LW-1:0] data_line
);
  localparam int HB = DW / 2;

  always_comb begin
    pc_line   = '0;
    pc_line[AW-1:0] = pc;
    addr_line = '0;
    addr_line[AW-1:0] = addr;
    addr_line[LW-1]   = size_byte;
    addr_line[LW-2]   = is_read;
    data_line = '0;
    if (size_byte) begin
      data_line[HB-1:0] = data[HB-1:0];
    end else begin
      data_line[DW-1:HB] = data[HB-1:0];
      data_line[HB-1:0]  = data[DW-1:HB];
    end
  end
endmodule

// File: rtl/trc_ram.sv
module trc_ram #(
  parameter int DEPTH = 64,
  parameter int LW    = 20,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [LW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [LW-1:0] rdata
);
  logic [LW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/trc_ctrl.sv
module trc_ctrl #(
  parameter int DEPTH = 64,
  parameter int AW    = 18,
  parameter int LW    = 20,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic          arm,
  input  logic          store,
  input  logic [AW-1:0] pc,
  input  logic [LW-1:0] pc_line,
  input  logic [LW-1:0] addr_line,
  input  logic [LW-1:0] data_line,
  output logic          we,
  output logic [IW-1:0] waddr,
  output logic [LW-1:0] wdata,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          pend
);
  import trc_pkg::*;

  localparam logic [CW-1:0] LAST = CW'(DEPTH);

  logic          armed_q;
  logic [CW-1:0] cnt_q;
  logic          full_q;
  logic          pend_q;
  logic [LW-1:0] pend_line_q;
  logic [AW-1:0] last_pc_q;
  logic          last_vld_q;
  logic          dup;
  logic          room;
  logic          accept;
  trc_mode_e     md;

  assign md     = trc_mode_e'(mode);
  assign dup    = (md == MODE_LOOP) && last_vld_q && (pc == last_pc_q);
  assign room   = (md == MODE_DETAIL) ? (cnt_q <= LAST - CW'(2)) : !full_q;
  assign accept = armed_q && !arm && store && !pend_q && room &&
                  (md != MODE_RSVD) && !dup;

  always_comb begin
    we    = 1'b0;
    waddr = cnt_q[IW-1:0];
    wdata = pc_line;
    if (!arm) begin
      if (pend_q) begin
        we    = 1'b1;
        wdata = pend_line_q;
      end else if (accept) begin
        we    = 1'b1;
        wdata = (md == MODE_DETAIL) ? addr_line : pc_line;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q     <= 1'b0;
      cnt_q       <= '0;
      full_q      <= 1'b0;
      pend_q      <= 1'b0;
      pend_line_q <= '0;
      last_pc_q   <= '0;
      last_vld_q  <= 1'b0;
    end else if (arm) begin
      armed_q    <= 1'b1;
      cnt_q      <= '0;
      full_q     <= 1'b0;
      pend_q     <= 1'b0;
      last_vld_q <= 1'b0;
    end else if (we) begin
      cnt_q  <= cnt_q + CW'(1);
      full_q <= (cnt_q + CW'(1)) == LAST;
      if (pend_q) begin
        pend_q <= 1'b0;
      end else if (md == MODE_DETAIL) begin
        pend_q      <= 1'b1;
        pend_line_q <= data_line;
      end else begin
        last_pc_q  <= pc;
        last_vld_q <= 1'b1;
      end
    end
  end

  assign cnt  = cnt_q;
  assign full = full_q;
  assign pend = pend_q;
endmodule

// File: rtl/trace_recorder.sv
module trace_recorder #(
  parameter int DEPTH = 64,
  parameter int AW    = 18,
  parameter int DW    = 16,
  parameter int LW    = 20,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode_i,
  input  logic          arm_i,
  input  logic          store_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          size_byte_i,
  input  logic          read_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [LW-1:0] rd_line_o,
  output logic [CW-1:0] line_cnt_o,
  output logic          full_o
);
  logic [LW-1:0] pc_line, addr_line, data_line, wdata;
  logic          we, pend_w;
  logic [IW-1:0] waddr;

  trc_line_fmt #(.AW(AW), .DW(DW), .LW(LW)) u_fmt (
    .pc(pc_i), .addr(addr_i), .data(data_i), .size_byte(size_byte_i),
    .is_read(read_i), .pc_line(pc_line), .addr_line(addr_line),
    .data_line(data_line)
  );

  trc_ctrl #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_ctrl (
    .clk(clk), .rst(rst), .mode(mode_i), .arm(arm_i), .store(store_i),
    .pc(pc_i), .pc_line(pc_line), .addr_line(addr_line),
    .data_line(data_line), .we(we), .waddr(waddr), .wdata(wdata),
    .cnt(line_cnt_o), .full(full_o), .pend(pend_w)
  );

  trc_ram #(.DEPTH(DEPTH), .LW(LW)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(rd_idx_i), .rdata(rd_line_o)
  );
endmodule

// File: rtl/trc_checker.sv
module trc_checker #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          arm,
  input logic [1:0]    mode,
  input logic [CW-1:0] cnt,
  input logic          full,
  input logic          pend
);
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  a_r9_full_match: assert property (@(posedge clk) disable iff (rst)
    full == (cnt == CW'(DEPTH)));

  a_r2_arm_clears: assert property (@(posedge clk) disable iff (rst)
    arm |=> (cnt == '0) && !full && !pend);

  a_r9_full_frozen: assert property (@(posedge clk) disable iff (rst)
    (full && !arm) |=> full && $stable(cnt));

  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    !arm |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + CW'(1)));

  a_r5_data_line_follows: assert property (@(posedge clk) disable iff (rst)
    (pend && !arm) |=> (cnt == $past(cnt) + CW'(1)) && !pend);

  a_r11_reserved_idle: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3 && !pend && !arm) |=> $stable(cnt));
endmodule

bind trace_recorder trc_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .arm(arm_i), .mode(mode_i),
  .cnt(line_cnt_o), .full(full_o), .pend(pend_w)
);

// File: tb/trace_recorder_tb.sv
`timescale 1ns/100ps
module trace_recorder_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic [1:0]  mode_i = 0;
  logic        arm_i = 0, store_i = 0, size_byte_i = 0, read_i = 0;
  logic [17:0] pc_i = 0, addr_i = 0;
  logic [15:0] data_i = 0;
  logic [5:0]  rd_idx_i = 0;
  logic [19:0] rd_line_o;
  logic [6:0]  line_cnt_o;
  logic        full_o;

  int tests = 0, fails = 0;
  logic [19:0] exp_mem [64];
  logic        done = 0;

  trace_recorder u_dut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .arm_i(arm_i), .store_i(store_i),
    .pc_i(pc_i), .addr_i(addr_i), .data_i(data_i), .size_byte_i(size_byte_i),
    .read_i(read_i), .rd_idx_i(rd_idx_i), .rd_line_o(rd_line_o),
    .line_cnt_o(line_cnt_o), .full_o(full_o)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_arm();
    arm_i = 1; cyc(); arm_i = 0;
  endtask

  task automatic store_pc(input logic [17:0] pc);
    pc_i = pc; store_i = 1; cyc(); store_i = 0;
  endtask

  task automatic store_acc(input logic [17:0] a, input logic [15:0] d,
                           input logic b, input logic r);
    addr_i = a; data_i = d; size_byte_i = b; read_i = r; store_i = 1;
    cyc(); store_i = 0;
  endtask

  task automatic dump(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      rd_idx_i = 6'(i); #0.5;
      check(req, {12'h0, rd_line_o}, {12'h0, exp_mem[i]});
    end
  endtask

  function automatic logic [19:0] pcl(input logic [17:0] p);
    return {2'b00, p};
  endfunction

  function automatic logic [19:0] al(input logic [17:0] a, input logic b, input logic r);
    return {b, r, a};
  endfunction

  function automatic logic [19:0] dl(input logic [15:0] d, input logic b);
    return b ? {12'h000, d[7:0]} : {4'h0, d[7:0], d[15:8]};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [17:0] last;
    logic        lv;
    int          n;
    repeat (3) cyc();
    rst = 0;
    check("R1 count after reset", line_cnt_o, 0);
    check("R1 full after reset", full_o, 0);
    store_pc(18'h12345); cyc();
    check("R1 strobe while disarmed", line_cnt_o, 0);

    // Normal mode fill and overflow
    mode_i = 2'd0; do_arm();
    check("R2 count after arm", line_cnt_o, 0);
    for (int k = 0; k < 64; k++) begin
      logic [17:0] p;
      p = 18'((k * 18'h0AB1D + 18'h2A5C3) & 18'h3FFFF);
      if (k % 7 == 3) p = 18'h2A5C3;
      exp_mem[k] = pcl(p);
      store_pc(p);
      check("R3 count step", line_cnt_o, 32'(k + 1));
      check("R9 full flag", full_o, (k == 63) ? 1 : 0);
    end
    store_pc(18'h3FFFF); store_pc(18'h00001);
    check("R9 count saturates", line_cnt_o, 64);
    check("R9 still full", full_o, 1);
    dump("R3/R9 normal contents", 64);
    rd_idx_i = 6'd5; #0.5;
    check("R10 comb read", rd_line_o, exp_mem[5]);
    rd_idx_i = 6'd40; #0.5;
    check("R10 comb read", rd_line_o, exp_mem[40]);

    // Re-arm clears full
    do_arm();
    check("R2 rearm count", line_cnt_o, 0);
    check("R2 rearm full", full_o, 0);

    // Loop mode duplicate filter
    mode_i = 2'd1; do_arm();
    lv = 0; last = 0; n = 0;
    for (int k = 0; k < 50; k++) begin
      logic [17:0] p;
      p = (k % 5 < 2) ? 18'h155AA : 18'(((k / 2) * 18'h01357) & 18'h3FFFF);
      if (!(lv && p == last)) begin
        exp_mem[n] = pcl(p); n++; last = p; lv = 1;
      end
      store_pc(p);
      check("R4 loop count", line_cnt_o, 32'(n));
    end
    dump("R4 loop contents", n);
    do_arm();
    store_pc(last); store_pc(last);
    check("R2 arm forgets last pc", line_cnt_o, 1);

    // Reserved mode
    mode_i = 2'd3; do_arm();
    for (int k = 0; k < 4; k++) store_pc(18'(k * 3 + 1));
    check("R11 reserved ignored", line_cnt_o, 0);

    // Detail mode: 32 entries, all size/direction combos
    mode_i = 2'd2; do_arm();
    for (int k = 0; k < 32; k++) begin
      logic [17:0] a;
      logic [15:0] d;
      logic b, r;
      a = 18'((k * 18'h0C3A7 + 18'h10F0F) & 18'h3FFFF);
      d = 16'((k * 16'h1D3B + 16'hA55A) & 16'hFFFF);
      b = k[0]; r = k[1];
      exp_mem[2*k] = al(a, b, r);
      exp_mem[2*k+1] = dl(d, b);
      store_acc(a, d, b, r);
      check("R5 count after address line", line_cnt_o, 32'(2*k + 1));
      cyc();
      check("R5 count after data line", line_cnt_o, 32'(2*k + 2));
    end
    check("R9 detail full", full_o, 1);
    store_acc(18'h3FFFF, 16'hFFFF, 1'b0, 1'b1);
    check("R9 detail count holds", line_cnt_o, 64);
    dump("R5/R6/R7 detail contents", 64);
    rd_idx_i = 6'd1; #0.5;
    check("R6 word byte swap", rd_line_o, dl(16'hA55A, 1'b0));
    rd_idx_i = 6'd3; #0.5;
    check("R7 byte low only", rd_line_o[15:8], 8'h00);

    // Strobe during data-line cycle
    do_arm();
    addr_i = 18'h2BEEF; data_i = 16'h1234; size_byte_i = 0; read_i = 1;
    store_i = 1; cyc();
    addr_i = 18'h01111; data_i = 16'h5678; size_byte_i = 1; read_i = 0;
    cyc(); store_i = 0;
    check("R8 back-to-back count", line_cnt_o, 2);
    cyc();
    check("R8 no extra line", line_cnt_o, 2);
    rd_idx_i = 6'd0; #0.5;
    check("R8 address line", rd_line_o, al(18'h2BEEF, 1'b0, 1'b1));
    rd_idx_i = 6'd1; #0.5;
    check("R8 data line", rd_line_o, dl(16'h1234, 1'b0));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule